// File: doc/BRIEF.md
# Floating-Point Classify and Compare Unit

This block examines two packed binary floating-point operands whose exponent and fraction widths are set by parameters. For each operand it reports one class out of five (zero, subnormal, normal, infinite, not-a-number) and two sign predicates. For the pair, it evaluates the five numeric relations equal, less, less-or-equal, greater and greater-or-equal. These relations treat both zeros as the same value and are all false whenever a not-a-number takes part.

The unit also gives a bit-level ordering of the two encodings, which callers use to sort non-NaN values. In this ordering every negative encoding, including negative zero, sits below every positive one. The ordering is flagged invalid when either operand is a not-a-number.

The unit is purely combinational. It holds no state and has no clock, so it can sit directly in a compare or branch path.

Top module: `fpcc_unit`

## Requirements
- R1: Each class output is a 5-bit one-hot vector with bit 0 for zero (exponent all zeros, fraction zero), bit 1 for subnormal (exponent all zeros, fraction nonzero), bit 2 for normal (exponent neither all zeros nor all ones), bit 3 for infinite (exponent all ones, fraction zero) and bit 4 for NaN (exponent all ones, fraction nonzero).
- R2: The negative predicate equals the sign bit (the most significant bit) and the positive predicate equals its inverse, except that both are 0 for a NaN operand.
- R3: When either operand is NaN, eq, lt, le, gt, ge, tord_valid and tord_lt are all 0.
- R4: For any pair of zeros (+0 or -0 in either position), eq, le and ge are 1, and lt and gt are 0.
- R5: For non-NaN operands, lt is 1 exactly when the value of a is below the value of b, where the infinities are the extreme values.
- R6: gt equals lt with the operands exchanged, and ge equals le with the operands exchanged.
- R7: le equals lt OR eq. For non-NaN operands that are not both zero, eq is 1 exactly when the two encodings are identical.
- R8: When neither operand is NaN, tord_valid is 1. In that case tord_lt is 1 exactly when a is ordered below b by these rules: a sign-1 encoding is below a sign-0 encoding (so -0 is below +0); two positive encodings are compared as unsigned {exponent, fraction}; for two negative encodings that comparison is reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | EXP_W+FRAC_W+1 | Operand a, packed as sign, exponent, fraction |
| b_i | input | EXP_W+FRAC_W+1 | Operand b, packed the same way |
| a_class_o | output | 5 | One-hot class of a |
| b_class_o | output | 5 | One-hot class of b |
| a_neg_o | output | 1 | a is negative and not NaN |
| a_pos_o | output | 1 | a is positive and not NaN |
| b_neg_o | output | 1 | b is negative and not NaN |
| b_pos_o | output | 1 | b is positive and not NaN |
| eq_o | output | 1 | a equals b numerically |
| lt_o | output | 1 | a is less than b |
| le_o | output | 1 | a is less than or equal to b |
| gt_o | output | 1 | a is greater than b |
| ge_o | output | 1 | a is greater than or equal to b |
| tord_valid_o | output | 1 | Neither operand is NaN, so tord_lt_o is meaningful |
| tord_lt_o | output | 1 | a is below b in the bit-level order |

## Verification
The unit is tried with a hand-written table of pairs, with their expected relations, at the places where the numeric and bit-level orders split. These pairs cover mixed-sign zeros, negative pairs in which the larger magnitude is the smaller value, the boundary between subnormal and normal, each infinity against the largest finite value, and NaN in either position. A long pseudo-random stream follows. It is weighted towards all-zero and all-ones exponents and zero fractions. Every relation in this stream is compared with a reference that decodes each operand to a real value, so any disagreement between encoding order and numeric order shows up. The same stream checks the classes and the bit-level order against a separately computed signed key, which tells a wrong sign reversal apart from a wrong zero rule.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

   localparam int CLS_N    = 5;
   localparam int CLS_ZERO = 0;
   localparam int CLS_SUB  = 1;
   localparam int CLS_NORM = 2;
   localparam int CLS_INF  = 3;
   localparam int CLS_NAN  = 4;

   typedef logic [CLS_N-1:0] cls_vec_t;

endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
   import fpcc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = EXP_W + FRAC_W + 1,
   localparam int MAG_W = EXP_W + FRAC_W
) (
   input  logic [W-1:0]     op_i,
   output cls_vec_t         cls_o,
   output logic             sign_o,
   output logic [MAG_W-1:0] mag_o,
   output logic             neg_o,
   output logic             pos_o
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_lo, exp_hi, frac_z;

   assign exp_f  = op_i[W-2 -: EXP_W];
   assign frac_f = op_i[FRAC_W-1:0];
   assign sign_o = op_i[W-1];
   assign mag_o  = op_i[MAG_W-1:0];

   assign exp_lo = (exp_f == '0);
   assign exp_hi = (exp_f == '1);
   assign frac_z = (frac_f == '0);

   always_comb begin
      cls_o           = '0;
      cls_o[CLS_ZERO] = exp_lo & frac_z;
      cls_o[CLS_SUB]  = exp_lo & ~frac_z;
      cls_o[CLS_NORM] = ~exp_lo & ~exp_hi;
      cls_o[CLS_INF]  = exp_hi & frac_z;
      cls_o[CLS_NAN]  = exp_hi & ~frac_z;
   end

   assign neg_o = sign_o & ~cls_o[CLS_NAN];
   assign pos_o = ~sign_o & ~cls_o[CLS_NAN];

   always_comb begin
      assert_class_onehot_R1: assert ($onehot(cls_o))
         else $error("class vector not one-hot: %b", cls_o);
      assert_sign_exclusive_R2: assert (!(neg_o && pos_o))
         else $error("operand both negative and positive");
      assert_nan_unsigned_R2: assert (!(cls_o[CLS_NAN] && (neg_o || pos_o)))
         else $error("NaN operand reports a sign");
   end

endmodule

// File: rtl/fpcc_order.sv
module fpcc_order #(
   parameter int MAG_W = 31
) (
   input  logic             x_sign_i,
   input  logic [MAG_W-1:0] x_mag_i,
   input  logic             y_sign_i,
   input  logic [MAG_W-1:0] y_mag_i,
   output logic             below_o
);

   logic mag_lt, mag_gt;

   assign mag_lt = (x_mag_i < y_mag_i);
   assign mag_gt = (x_mag_i > y_mag_i);

   always_comb begin
      if (x_sign_i != y_sign_i) begin
         below_o = x_sign_i;
      end else if (x_sign_i) begin
         below_o = mag_gt;
      end else begin
         below_o = mag_lt;
      end
   end

   always_comb begin
      assert_equal_not_below_R8: assert (!(below_o && x_sign_i == y_sign_i && x_mag_i == y_mag_i))
         else $error("identical encodings ordered as below");
   end

endmodule

// File: rtl/fpcc_relate.sv
module fpcc_relate (
   input  logic a_zero_i,
   input  logic a_nan_i,
   input  logic b_zero_i,
   input  logic b_nan_i,
   input  logic a_below_b_i,
   input  logic b_below_a_i,
   output logic eq_o,
   output logic lt_o,
   output logic le_o,
   output logic gt_o,
   output logic ge_o,
   output logic tord_valid_o,
   output logic tord_lt_o
);

   logic any_nan, both_zero, same_enc;

   assign any_nan   = a_nan_i | b_nan_i;
   assign both_zero = a_zero_i & b_zero_i;
   assign same_enc  = ~a_below_b_i & ~b_below_a_i;

   assign tord_valid_o = ~any_nan;
   assign tord_lt_o    = ~any_nan & a_below_b_i;

   assign eq_o = ~any_nan & (both_zero | same_enc);
   assign lt_o = ~any_nan & ~both_zero & a_below_b_i;
   assign gt_o = ~any_nan & ~both_zero & b_below_a_i;
   assign le_o = lt_o | eq_o;
   assign ge_o = gt_o | eq_o;

   always_comb begin
      assert_nan_all_false_R3: assert (!(any_nan && (eq_o || lt_o || le_o || gt_o || ge_o || tord_lt_o)))
         else $error("relation true with NaN operand");
      assert_zero_pair_equal_R4: assert (!(both_zero && !any_nan && !(eq_o && !lt_o && !gt_o)))
         else $error("signed zeros not equal");
      assert_lt_gt_exclusive_R6: assert (!(lt_o && gt_o))
         else $error("lt and gt both set");
      assert_order_antisym_R8: assert (!(a_below_b_i && b_below_a_i))
         else $error("each operand below the other");
      assert_eq_excludes_lt_R7: assert (!(eq_o && (lt_o || gt_o)))
         else $error("eq together with strict relation");
   end

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
   import fpcc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = EXP_W + FRAC_W + 1,
   localparam int MAG_W = EXP_W + FRAC_W
) (
   input  logic [W-1:0]     a_i,
   input  logic [W-1:0]     b_i,
   output logic [CLS_N-1:0] a_class_o,
   output logic [CLS_N-1:0] b_class_o,
   output logic             a_neg_o,
   output logic             a_pos_o,
   output logic             b_neg_o,
   output logic             b_pos_o,
   output logic             eq_o,
   output logic             lt_o,
   output logic             le_o,
   output logic             gt_o,
   output logic             ge_o,
   output logic             tord_valid_o,
   output logic             tord_lt_o
);

   if (EXP_W < 2) begin : g_bad_exp
      $error("EXP_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("FRAC_W must be at least 1");
   end

   localparam int NOPS = 2;

   logic [NOPS-1:0][W-1:0]     ops;
   cls_vec_t                   cls   [NOPS];
   logic [NOPS-1:0]            sgn;
   logic [NOPS-1:0][MAG_W-1:0] mag;
   logic [NOPS-1:0]            neg, pos;
   logic [NOPS-1:0]            below;

   assign ops[0] = a_i;
   assign ops[1] = b_i;

   for (genvar k = 0; k < NOPS; k++) begin : g_cls
      fpcc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .op_i   (ops[k]),
         .cls_o  (cls[k]),
         .sign_o (sgn[k]),
         .mag_o  (mag[k]),
         .neg_o  (neg[k]),
         .pos_o  (pos[k])
      );
   end

   // direction 0: a below b; direction 1: b below a
   for (genvar d = 0; d < NOPS; d++) begin : g_ord
      fpcc_order #(.MAG_W(MAG_W)) u_ord (
         .x_sign_i (sgn[d]),
         .x_mag_i  (mag[d]),
         .y_sign_i (sgn[NOPS-1-d]),
         .y_mag_i  (mag[NOPS-1-d]),
         .below_o  (below[d])
      );
   end

   fpcc_relate u_rel (
      .a_zero_i     (cls[0][CLS_ZERO]),
      .a_nan_i      (cls[0][CLS_NAN]),
      .b_zero_i     (cls[1][CLS_ZERO]),
      .b_nan_i      (cls[1][CLS_NAN]),
      .a_below_b_i  (below[0]),
      .b_below_a_i  (below[1]),
      .eq_o         (eq_o),
      .lt_o         (lt_o),
      .le_o         (le_o),
      .gt_o         (gt_o),
      .ge_o         (ge_o),
      .tord_valid_o (tord_valid_o),
      .tord_lt_o    (tord_lt_o)
   );

   assign a_class_o = cls[0];
   assign b_class_o = cls[1];
   assign a_neg_o   = neg[0];
   assign a_pos_o   = pos[0];
   assign b_neg_o   = neg[1];
   assign b_pos_o   = pos[1];

   always_comb begin
      assert_le_is_lt_or_eq_R7: assert (le_o == (lt_o | eq_o))
         else $error("le disagrees with lt|eq");
      assert_tord_valid_nan_R8: assert (tord_valid_o == !(a_class_o[CLS_NAN] || b_class_o[CLS_NAN]))
         else $error("tord_valid disagrees with operand classes");
      assert_strict_implies_tord_R5: assert (!(lt_o && !tord_lt_o))
         else $error("numeric lt without bit-level order");
   end

endmodule

// File: tb/tb_fpcc_unit.sv
`timescale 1ns/1ps
module tb_fpcc_unit;

   localparam int EW = 5;
   localparam int FW = 10;
   localparam int W  = EW + FW + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [W-1:0] a, b;
   logic [4:0]   a_cls, b_cls;
   logic a_neg, a_pos, b_neg, b_pos;
   logic eq, lt, le, gt, ge, tv, tlt;

   fpcc_unit #(.EXP_W(EW), .FRAC_W(FW)) dut (
      .a_i(a), .b_i(b),
      .a_class_o(a_cls), .b_class_o(b_cls),
      .a_neg_o(a_neg), .a_pos_o(a_pos), .b_neg_o(b_neg), .b_pos_o(b_pos),
      .eq_o(eq), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge),
      .tord_valid_o(tv), .tord_lt_o(tlt)
   );

   int  total = 0;
   int  bad   = 0;
   bit  done  = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h a=%h b=%h", req, act, exp, a, b);
      end
   endtask

   // table entries: a, b, expected {lt, eq, gt}
   typedef struct packed {
      logic [15:0] a;
      logic [15:0] b;
      logic [2:0]  leg;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VT [NV] = '{
      '{16'h0000, 16'h8000, 3'b010},
      '{16'h8000, 16'h0000, 3'b010},
      '{16'h3C00, 16'h4000, 3'b100},
      '{16'hBC00, 16'h3C00, 3'b100},
      '{16'hBC00, 16'hC000, 3'b001},
      '{16'h7C00, 16'h7BFF, 3'b001},
      '{16'hFC00, 16'hFBFF, 3'b100},
      '{16'h7E00, 16'h7E00, 3'b000},
      '{16'h3C00, 16'hFE01, 3'b000},
      '{16'h0001, 16'h8000, 3'b001},
      '{16'h03FF, 16'h0400, 3'b100},
      '{16'h3C00, 16'h3C00, 3'b010},
      '{16'h8001, 16'h0000, 3'b100},
      '{16'hFC00, 16'h7C00, 3'b100}
   };

   function automatic bit is_nan(logic [W-1:0] x);
      return (x[W-2:FW] == '1) && (x[FW-1:0] != '0);
   endfunction

   function automatic logic [4:0] ref_cls(logic [W-1:0] x);
      logic [EW-1:0] e = x[W-2:FW];
      logic [FW-1:0] f = x[FW-1:0];
      if (e == 0)       return (f == 0) ? 5'b00001 : 5'b00010;
      else if (e == '1) return (f == 0) ? 5'b01000 : 5'b10000;
      else              return 5'b00100;
   endfunction

   function automatic real p2(int n);
      real r = 1.0;
      if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
      else        for (int i = 0; i < -n; i++) r = r / 2.0;
      return r;
   endfunction

   function automatic real fval(logic [W-1:0] x);
      int  e = int'(x[W-2:FW]);
      int  f = int'(x[FW-1:0]);
      real m;
      if (e == 0)            m = real'(f) * p2(-24);
      else if (e == 31)      m = 1.0e30;
      else                   m = real'(1024 + f) * p2(e - 25);
      return x[W-1] ? -m : m;
   endfunction

   function automatic int okey(logic [W-1:0] x);
      int mg = int'(x[W-2:0]);
      return x[W-1] ? (-mg - 1) : mg;
   endfunction

   task automatic check_pair(input string tag);
      bit  anynan = is_nan(a) || is_nan(b);
      real va = fval(a);
      real vb = fval(b);
      bit  e_lt = !anynan && (va < vb);
      bit  e_gt = !anynan && (va > vb);
      bit  e_eq = !anynan && (va == vb);
      bit  e_tl = !anynan && (okey(a) < okey(b));
      check(a_cls == ref_cls(a), {"R1 a class ", tag}, a_cls, ref_cls(a));
      check(b_cls == ref_cls(b), {"R1 b class ", tag}, b_cls, ref_cls(b));
      check({a_neg, a_pos} == (is_nan(a) ? 2'b00 : {a[W-1], ~a[W-1]}), {"R2 a sign ", tag},
            {a_neg, a_pos}, is_nan(a) ? 2'b00 : {a[W-1], ~a[W-1]});
      check({b_neg, b_pos} == (is_nan(b) ? 2'b00 : {b[W-1], ~b[W-1]}), {"R2 b sign ", tag},
            {b_neg, b_pos}, is_nan(b) ? 2'b00 : {b[W-1], ~b[W-1]});
      check(lt == e_lt, {"R5 lt ", tag}, lt, e_lt);
      check(gt == e_gt, {"R6 gt ", tag}, gt, e_gt);
      check(eq == e_eq, {"R7 eq ", tag}, eq, e_eq);
      check(le == (e_lt | e_eq), {"R7 le ", tag}, le, e_lt | e_eq);
      check(ge == (e_gt | e_eq), {"R6 ge ", tag}, ge, e_gt | e_eq);
      check(tv == !anynan, {"R8 tord_valid ", tag}, tv, !anynan);
      check(tlt == e_tl, {"R8 tord_lt ", tag}, tlt, e_tl);
      if (anynan)
         check({eq, lt, le, gt, ge, tv, tlt} == 7'b0, {"R3 nan ", tag}, {eq, lt, le, gt, ge, tv, tlt}, 0);
   endtask

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
      @(posedge clk);
      a = x;
      b = y;
      @(negedge clk);
   endtask

   logic [31:0] rs = 32'h1234_5678;
   function automatic logic [31:0] nxt(logic [31:0] s);
      logic [31:0] t = s;
      t = t ^ (t << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   task automatic rand_op(output logic [W-1:0] x);
      logic [EW-1:0] e;
      logic [FW-1:0] f;
      rs = nxt(rs);
      case (rs[2:0])
         3'd0, 3'd1: e = '0;
         3'd2, 3'd3: e = '1;
         default:    e = rs[12:8];
      endcase
      f = rs[3] ? '0 : rs[22:13];
      x = {rs[31], e, f};
   endtask

   initial begin
      a = '0;
      b = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset state: both inputs +0
      check(a_cls == 5'b00001, "R1 reset class", a_cls, 1);
      check({eq, le, ge, lt, gt} == 5'b11100, "R4 reset zeros equal", {eq, le, ge, lt, gt}, 5'b11100);
      check(tv == 1'b1 && tlt == 1'b0, "R8 reset tord", {tv, tlt}, 2'b10);

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(VT[i].a, VT[i].b);
         check({lt, eq, gt} == VT[i].leg, "R5 table lt/eq/gt", {lt, eq, gt}, VT[i].leg);
         check(le == (VT[i].leg[2] | VT[i].leg[1]), "R7 table le", le, VT[i].leg[2] | VT[i].leg[1]);
         check(ge == (VT[i].leg[0] | VT[i].leg[1]), "R6 table ge", ge, VT[i].leg[0] | VT[i].leg[1]);
         check_pair("table");
      end

      // directed corner cases
      apply(16'h8000, 16'h0000);
      check(tlt == 1'b1, "R8 -0 below +0 in bit order", tlt, 1);
      check(lt == 1'b0 && eq == 1'b1, "R4 -0 vs +0 numeric", {lt, eq}, 2'b01);
      apply(16'h8000, 16'h8000);
      check({eq, le, ge} == 3'b111, "R4 -0 vs -0", {eq, le, ge}, 3'b111);
      apply(16'hFE00, 16'hFE00);
      check({eq, lt, le, gt, ge, tv, tlt} == 7'b0, "R3 identical NaN encodings", {eq, lt, le, gt, ge, tv, tlt}, 0);
      check({a_neg, a_pos} == 2'b00, "R2 negative NaN has no sign", {a_neg, a_pos}, 0);
      apply(16'hC000, 16'hBC00);
      check(tlt == 1'b1 && lt == 1'b1, "R8 negatives reversed", {tlt, lt}, 2'b11);
      apply(16'h7C01, 16'h0000);
      check(a_cls == 5'b10000, "R1 lowest NaN fraction", a_cls, 5'b10000);
      check_pair("directed");

      // pseudo-random sweep
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] x, y;
         rand_op(x);
         rand_op(y);
         apply(x, y);
         check_pair("random");
         apply(y, x);
         check_pair("random swapped");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000ns;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule